// File: doc/BRIEF.md
# Packet-Aware Transmit Byte Queue

This block sits between a packet source and a serial frame transmitter. It holds up to 256 bytes, each stored with a start-of-packet tag and an end-of-packet tag. The source pushes one byte per write. The transmitter pulls bytes from a show-ahead read port. A free-space flag tells the source when a programmable amount of room is left. The threshold is a 5-bit level, and the flag is high when the free byte count is at least level×8+1.

A flush control empties the queue and stops any transfer in progress. While flush is held, every write is ignored. After flush is released, and after reset, the write side hunts for a byte tagged start-of-packet and drops everything before it. This realigns the stored stream to a packet boundary.

To keep the transmitter from running dry straight after a packet starts, the read side holds back the first byte of a packet. It releases that byte once the packet's end byte is stored or once a set number of bytes (HEAD_BYTES, default 4) is buffered. After the first byte has gone, the rest of the packet is offered as soon as each byte is stored.

The write side is a state machine with three states:
- WR_FLUSH: writes are ignored. Releasing flush goes to WR_HUNT.
- WR_HUNT: only a byte tagged start-of-packet is stored. Storing it goes to WR_PASS.
- WR_PASS: every byte is stored while there is room.

From WR_HUNT or WR_PASS, flush goes to WR_FLUSH. Reset enters WR_HUNT.

The read side has two states:
- RD_HEAD: the head byte is held back until the release rule is met. Popping a head byte without the end tag goes to RD_BODY.
- RD_BODY: bytes are offered whenever the queue is not empty. Popping a byte with the end tag returns to RD_HEAD.

Flush and reset both return the read side to RD_HEAD.

Top module: `txpkt_fifo`

## Requirements
- R1: After reset, rd_valid and ovf are 0, and space_ok is 1 for any level, because all 256 bytes are free.
- R2: Writes made while flush is 1 are not stored. A complete packet written during flush is never offered after flush returns to 0.
- R3: After reset, and after flush returns to 0, bytes with wr_sop=0 are discarded. The first byte with wr_sop=1 and every byte after it are stored.
- R4: Bytes leave in write order, each with its own sop and eop tags on rd_sop and rd_eop.
- R5: space_ok = 1 exactly when (256 − stored bytes) ≥ lvl×8+1. For example, with lvl=21, 87 stored bytes give 1 and 88 give 0. A change of lvl takes effect in the same cycle.
- R6: A write made while 256 bytes are stored is dropped. ovf is 1 for the one cycle after that write edge, then returns to 0.
- R7: rd_en while rd_valid=0 removes nothing. The next byte that is offered is still the oldest stored byte.
- R8: The first byte of a packet is offered only once an end-tagged byte is stored or at least HEAD_BYTES (4) bytes are stored.
- R9: After a packet's first byte has been read, each later byte of that packet is offered in the cycle after it is written, with no hold-back.
- R10: rd_valid is 0 in any cycle in which flush is 1. After a flush the queue is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the queue, halt reads, ignore writes |
| lvl | input | 5 | Free-space threshold level (lvl×8+1 bytes) |
| wr_en | input | 1 | Write one byte |
| wr_data | input | 8 | Byte to write |
| wr_sop | input | 1 | Written byte starts a packet |
| wr_eop | input | 1 | Written byte ends a packet |
| rd_en | input | 1 | Pop the offered byte when rd_valid is 1 |
| rd_valid | output | 1 | A byte is offered on the read port |
| rd_data | output | 8 | Offered byte |
| rd_sop | output | 1 | Offered byte starts a packet |
| rd_eop | output | 1 | Offered byte ends a packet |
| space_ok | output | 1 | Free space is at or above the threshold |
| ovf | output | 1 | Pulse: a write was dropped because the queue was full |

## Verification
A write or pop at one rising edge shows on rd_valid, the read port and space_ok right after that edge. A dropped write shows on ovf for that one following cycle. A change of lvl or flush affects space_ok and rd_valid at once, with no edge in between. The bench drives inputs on falling edges and samples outputs on the next falling edge, so each result is read in the cycle it first becomes due. For the same-cycle effects of lvl and flush, it samples one time unit after driving them.

// File: rtl/txf_pkg.sv
package txf_pkg;

    localparam int TXF_DW = 8;

    typedef enum logic [1:0] {
        WR_FLUSH = 2'd0,
        WR_HUNT  = 2'd1,
        WR_PASS  = 2'd2
    } wr_state_t;

    typedef enum logic {
        RD_HEAD = 1'b0,
        RD_BODY = 1'b1
    } rd_state_t;

    typedef struct packed {
        logic              sop;
        logic              eop;
        logic [TXF_DW-1:0] data;
    } txf_ent_t;

endpackage

// File: rtl/txf_wr_ctrl.sv
module txf_wr_ctrl
    import txf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic wr_en,
    input  logic wr_sop,
    input  logic full,
    output logic push,
    output logic ovf
);

    wr_state_t state_q, state_d;
    logic      want_store;
    logic      ovf_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WR_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_FLUSH: if (!flush) state_d = WR_HUNT;
            WR_HUNT: begin
                if (flush) begin
                    state_d = WR_FLUSH;
                end else if (wr_en && wr_sop && !full) begin
                    state_d = WR_PASS;
                end
            end
            WR_PASS: if (flush) state_d = WR_FLUSH;
            default: state_d = WR_FLUSH;
        endcase
    end

    // outputs
    always_comb begin
        want_store = 1'b0;
        unique case (state_q)
            WR_FLUSH: want_store = 1'b0;
            WR_HUNT:  want_store = wr_en && wr_sop && !flush;
            WR_PASS:  want_store = wr_en && !flush;
            default:  want_store = 1'b0;
        endcase
        push  = want_store && !full;
        ovf_d = want_store && full;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else begin
            ovf <= ovf_d;
        end
    end

endmodule

// File: rtl/txf_store.sv
module txf_store
    import txf_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  txf_ent_t      wr_ent,
    output txf_ent_t      rd_ent,
    output logic [ADDR_W:0] count,
    output logic [ADDR_W:0] pkt_cnt,
    output logic          empty,
    output logic          full
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W:0] DEPTH_CNT = (ADDR_W+1)'(DEPTH);

    txf_ent_t          mem_q [DEPTH];
    logic [ADDR_W-1:0] wp_q, rp_q;
    logic [ADDR_W:0]   cnt_q, pkts_q;
    logic              eop_in, eop_out;

    assign eop_in  = push && wr_ent.eop;
    assign eop_out = pop && rd_ent.eop;

    always_ff @(posedge clk) begin
        if (push) begin
            mem_q[wp_q] <= wr_ent;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q   <= '0;
            rp_q   <= '0;
            cnt_q  <= '0;
            pkts_q <= '0;
        end else if (flush) begin
            wp_q   <= '0;
            rp_q   <= '0;
            cnt_q  <= '0;
            pkts_q <= '0;
        end else begin
            if (push) wp_q <= wp_q + 1'b1;
            if (pop)  rp_q <= rp_q + 1'b1;
            unique case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
            unique case ({eop_in, eop_out})
                2'b10:   pkts_q <= pkts_q + 1'b1;
                2'b01:   pkts_q <= pkts_q - 1'b1;
                default: pkts_q <= pkts_q;
            endcase
        end
    end

    assign rd_ent  = mem_q[rp_q];
    assign count   = cnt_q;
    assign pkt_cnt = pkts_q;
    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == DEPTH_CNT);

endmodule

// File: rtl/txf_rd_ctrl.sv
module txf_rd_ctrl
    import txf_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int HEAD_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            rd_en,
    input  logic            empty,
    input  logic [ADDR_W:0] count,
    input  logic [ADDR_W:0] pkt_cnt,
    input  logic            head_eop,
    output logic            pop,
    output logic            rd_valid
);

    localparam logic [ADDR_W:0] HEAD_LIM = (ADDR_W+1)'(HEAD_BYTES);

    rd_state_t state_q, state_d;
    logic      release_ok;

    assign release_ok = (pkt_cnt != '0) || (count >= HEAD_LIM);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_HEAD;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_HEAD: begin
                if (flush) begin
                    state_d = RD_HEAD;
                end else if (pop && !head_eop) begin
                    state_d = RD_BODY;
                end
            end
            RD_BODY: begin
                if (flush) begin
                    state_d = RD_HEAD;
                end else if (pop && head_eop) begin
                    state_d = RD_HEAD;
                end
            end
            default: state_d = RD_HEAD;
        endcase
    end

    // outputs
    always_comb begin
        rd_valid = 1'b0;
        unique case (state_q)
            RD_HEAD: rd_valid = !flush && !empty && release_ok;
            RD_BODY: rd_valid = !flush && !empty;
            default: rd_valid = 1'b0;
        endcase
        pop = rd_valid && rd_en;
    end

endmodule

// File: rtl/txf_level.sv
module txf_level #(
    parameter int ADDR_W = 8,
    parameter int LVL_W  = 5
) (
    input  logic [ADDR_W:0]  count,
    input  logic [LVL_W-1:0] lvl,
    output logic             space_ok
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int NW = (((LVL_W + 3) > (ADDR_W + 1)) ? (LVL_W + 3) : (ADDR_W + 1)) + 1;

    logic [NW-1:0] free_w;
    logic [NW-1:0] need_w;

    assign free_w   = NW'(DEPTH) - NW'(count);
    assign need_w   = NW'({lvl, 3'b000}) + NW'(1);
    assign space_ok = (free_w >= need_w);

endmodule

// File: rtl/txpkt_fifo.sv
module txpkt_fifo
    import txf_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int LVL_W      = 5,
    parameter int HEAD_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [LVL_W-1:0] lvl,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             wr_sop,
    input  logic             wr_eop,
    input  logic             rd_en,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             rd_sop,
    output logic             rd_eop,
    output logic             space_ok,
    output logic             ovf
);

    txf_ent_t        wr_ent, rd_ent;
    logic            push, pop, empty, full;
    logic [ADDR_W:0] count, pkt_cnt;

    assign wr_ent = '{sop: wr_sop, eop: wr_eop, data: wr_data};

    txf_wr_ctrl u_wr (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .wr_en  (wr_en),
        .wr_sop (wr_sop),
        .full   (full),
        .push   (push),
        .ovf    (ovf)
    );

    txf_store #(.ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .push    (push),
        .pop     (pop),
        .wr_ent  (wr_ent),
        .rd_ent  (rd_ent),
        .count   (count),
        .pkt_cnt (pkt_cnt),
        .empty   (empty),
        .full    (full)
    );

    txf_rd_ctrl #(.ADDR_W(ADDR_W), .HEAD_BYTES(HEAD_BYTES)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .rd_en    (rd_en),
        .empty    (empty),
        .count    (count),
        .pkt_cnt  (pkt_cnt),
        .head_eop (rd_ent.eop),
        .pop      (pop),
        .rd_valid (rd_valid)
    );

    txf_level #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_lvl (
        .count    (count),
        .lvl      (lvl),
        .space_ok (space_ok)
    );

    assign rd_data = rd_ent.data;
    assign rd_sop  = rd_ent.sop;
    assign rd_eop  = rd_ent.eop;

endmodule

// File: rtl/txpkt_fifo_chk.sv
module txpkt_fifo_chk #(
    parameter int ADDR_W     = 8,
    parameter int LVL_W      = 5,
    parameter int HEAD_BYTES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic [LVL_W-1:0] lvl,
    input logic             wr_en,
    input logic             rd_en,
    input logic             rd_valid,
    input logic [7:0]       rd_data,
    input logic             rd_sop,
    input logic             space_ok,
    input logic             ovf
);

    localparam int DEPTH   = 1 << ADDR_W;
    localparam int MIN_CNT = DEPTH - ((1 << LVL_W) - 1) * 8;

    // set after reset or flush, cleared by the first pop that follows
    logic fresh_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fresh_q <= 1'b1;
        end else if (flush) begin
            fresh_q <= 1'b1;
        end else if (rd_valid && rd_en) begin
            fresh_q <= 1'b0;
        end
    end

    AST_FIRST_IS_SOP: assert property (@(posedge clk) disable iff (!rst_n)
        fresh_q && rd_valid |-> rd_sop); // R3

    AST_FLUSH_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !rd_valid); // R10

    AST_FLUSH_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> space_ok); // R10

    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> $past(wr_en) && !$past(flush)); // R6

    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_en && !flush |=> flush || (rd_valid && $stable(rd_data) && $stable(rd_sop))); // R7

    generate
        if (MIN_CNT >= HEAD_BYTES && MIN_CNT >= 1) begin : g_low_space
            AST_LOW_SPACE_OFFERS: assert property (@(posedge clk) disable iff (!rst_n)
                !space_ok && !flush |-> rd_valid); // R8
        end
    endgenerate

endmodule

bind txpkt_fifo txpkt_fifo_chk #(
    .ADDR_W     (ADDR_W),
    .LVL_W      (LVL_W),
    .HEAD_BYTES (HEAD_BYTES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .lvl      (lvl),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rd_sop   (rd_sop),
    .space_ok (space_ok),
    .ovf      (ovf)
);

// File: tb/txpkt_fifo_bench.sv
`timescale 1ns/1ps
module txpkt_fifo_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush = 1'b0;
    logic [4:0] lvl = 5'd16;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_sop = 1'b0;
    logic       wr_eop = 1'b0;
    logic       rd_en = 1'b0;
    logic       rd_valid, rd_sop, rd_eop, space_ok, ovf;
    logic [7:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    txpkt_fifo u_txpkt_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush), .lvl(lvl),
        .wr_en(wr_en), .wr_data(wr_data), .wr_sop(wr_sop), .wr_eop(wr_eop),
        .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_sop(rd_sop), .rd_eop(rd_eop), .space_ok(space_ok), .ovf(ovf)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] d, input logic s, input logic e);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_sop = s; wr_eop = e;
        @(negedge clk);
        wr_en = 1'b0; wr_sop = 1'b0; wr_eop = 1'b0;
    endtask

    // pop the offered byte and check it; called on a falling edge
    task automatic pop_chk(input string req, input logic [7:0] d, input logic s, input logic e);
        chk({req, " valid"}, int'(rd_valid), 1);
        chk({req, " data"}, int'({rd_sop, rd_eop, rd_data}), int'({s, e, d}));
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 rd_valid", int'(rd_valid), 0);
        chk("R1 ovf", int'(ovf), 0);
        lvl = 5'd31; #1;
        chk("R1 space_ok lvl31", int'(space_ok), 1);
        lvl = 5'd16;
    endtask

    task automatic t_hunt;
        wr_byte(8'h11, 1'b0, 1'b0);
        wr_byte(8'h22, 1'b0, 1'b1);
        chk("R3 leading bytes dropped", int'(rd_valid), 0);
        wr_byte(8'hA0, 1'b1, 1'b0);
        wr_byte(8'hA1, 1'b0, 1'b0);
        wr_byte(8'hA2, 1'b0, 1'b1);
        pop_chk("R4 byte0", 8'hA0, 1'b1, 1'b0);
        pop_chk("R4 byte1", 8'hA1, 1'b0, 1'b0);
        pop_chk("R4 byte2", 8'hA2, 1'b0, 1'b1);
        chk("R4 drained", int'(rd_valid), 0);
    endtask

    task automatic t_hold;
        wr_byte(8'hB0, 1'b1, 1'b0);
        chk("R8 held at 1", int'(rd_valid), 0);
        wr_byte(8'hB1, 1'b0, 1'b0);
        wr_byte(8'hB2, 1'b0, 1'b0);
        chk("R8 held at 3", int'(rd_valid), 0);
        wr_byte(8'hB3, 1'b0, 1'b0);
        chk("R8 released at 4", int'(rd_valid), 1);
        for (int i = 0; i < 4; i++) pop_chk("R8 body", 8'hB0 + 8'(i), (i == 0), 1'b0);
        chk("R9 empty mid packet", int'(rd_valid), 0);
        wr_byte(8'hB4, 1'b0, 1'b1);
        chk("R9 offered at once", int'(rd_valid), 1);
        pop_chk("R9 tail", 8'hB4, 1'b0, 1'b1);
        wr_byte(8'hC0, 1'b1, 1'b0);
        chk("R8 short held", int'(rd_valid), 0);
        wr_byte(8'hC1, 1'b0, 1'b1);
        chk("R8 short released on end", int'(rd_valid), 1);
        pop_chk("R8 short0", 8'hC0, 1'b1, 1'b0);
        pop_chk("R8 short1", 8'hC1, 1'b0, 1'b1);
    endtask

    task automatic t_empty_read;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        wr_byte(8'hD0, 1'b1, 1'b0);
        wr_byte(8'hD1, 1'b0, 1'b0);
        wr_byte(8'hD2, 1'b0, 1'b1);
        pop_chk("R7 head after empty read", 8'hD0, 1'b1, 1'b0);
        pop_chk("R7 next", 8'hD1, 1'b0, 1'b0);
        pop_chk("R7 last", 8'hD2, 1'b0, 1'b1);
    endtask

    task automatic t_level;
        int errs;
        lvl = 5'd21;
        for (int i = 0; i < 87; i++) wr_byte(8'(i), (i == 0), 1'b0);
        chk("R5 169 free lvl21", int'(space_ok), 1);
        wr_byte(8'd87, 1'b0, 1'b0);
        chk("R5 168 free lvl21", int'(space_ok), 0);
        lvl = 5'd20; #1;
        chk("R5 168 free lvl20", int'(space_ok), 1);
        lvl = 5'd0;
        for (int i = 88; i < 255; i++) wr_byte(8'(i), 1'b0, 1'b0);
        chk("R5 1 free lvl0", int'(space_ok), 1);
        wr_byte(8'd255, 1'b0, 1'b1);
        chk("R5 full lvl0", int'(space_ok), 0);
        chk("R6 no ovf on last fit", int'(ovf), 0);
        wr_byte(8'hEE, 1'b1, 1'b1);
        chk("R6 ovf pulse", int'(ovf), 1);
        @(negedge clk);
        chk("R6 ovf one cycle", int'(ovf), 0);
        errs = 0;
        for (int i = 0; i < 256; i++) begin
            if (!rd_valid || rd_data != 8'(i) || rd_sop != (i == 0) || rd_eop != (i == 255))
                errs++;
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
        chk("R4 256-byte order", errs, 0);
        chk("R6 dropped byte absent", int'(rd_valid), 0);
        lvl = 5'd16;
    endtask

    task automatic t_flush;
        for (int i = 0; i < 5; i++) wr_byte(8'hE0 + 8'(i), (i == 0), 1'b0);
        pop_chk("R10 pre-flush", 8'hE0, 1'b1, 1'b0);
        flush = 1'b1; #1;
        chk("R10 halted during flush", int'(rd_valid), 0);
        wr_byte(8'hF0, 1'b1, 1'b0);
        wr_byte(8'hF1, 1'b0, 1'b1);
        chk("R10 still halted", int'(rd_valid), 0);
        flush = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 flushed writes absent", int'(rd_valid), 0);
        wr_byte(8'h51, 1'b0, 1'b0);
        wr_byte(8'h52, 1'b0, 1'b1);
        chk("R3 hunt after flush", int'(rd_valid), 0);
        wr_byte(8'h60, 1'b1, 1'b0);
        wr_byte(8'h61, 1'b0, 1'b1);
        pop_chk("R3 first after flush", 8'h60, 1'b1, 1'b0);
        pop_chk("R3 second after flush", 8'h61, 1'b0, 1'b1);
        chk("R10 empty at end", int'(rd_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hunt();
        t_hold();
        t_empty_read();
        t_level();
        t_flush();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule